// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions towards an Ethernet PHY over the two-wire serial management bus. A requester presents an operation (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then emits one complete frame: a run of ones that lets the PHY lock on, a header, and either 16 driven data bits (write) or a released line from which it samples the PHY's answer (read). When the frame is over it raises `done` for one cycle, and for reads it presents the 16-bit result on `rd_data`.

The serial clock is derived from the system clock. Each bit occupies one slot of `2*DIV` system clocks: `DIV` clocks with the serial clock low, then `DIV` clocks with it high. The data line is driven through an output enable, so that on reads the PHY can take the line. Reads and writes both last 64 slots, so every transaction takes `128*DIV` system clocks.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever no transaction is in progress, `mdc` is low, `mdio_oe` is low and `busy` is low.
- R2: Every transaction begins with 32 serial clock periods during which the data line is driven high (`mdio_oe`=1, `mdio_o`=1 at each rising `mdc` edge).
- R3: A read drives, after the run of ones and most significant bit first, the 14 bits 0,1,1,0, then the PHY address, then the register address.
- R4: After its 14 header bits a read releases the line (`mdio_oe`=0) for 18 further serial clock periods.
- R5: During those 18 periods the block samples `mdio_i` once per period, in the last system clock before the rising `mdc` edge; `rd_data` then holds the last 16 samples, the earliest of them in bit 15.
- R6: A write drives, after the run of ones and most significant bit first, 32 bits: 0,1,0,1, PHY address, register address, 1,0, then the 16 data bits.
- R7: `mdio_o` and `mdio_oe` change only while `mdc` is low; they hold still during each high phase of `mdc`.
- R8: `mdc` is high for exactly `DIV` system clocks and low for `DIV` system clocks in each period. `done` rises `128*DIV` clocks after the edge that accepts the request.
- R9: A request presented while `busy` is high is ignored: the running frame is not altered and no transaction follows it.
- R10: `done` is high for exactly one cycle at the end of each transaction, with `busy`, `mdc` and `mdio_oe` already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a transaction (taken only while idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address within the PHY |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rd_data | output | 16 | Result of the last read, valid with `done` |
| mdc | output | 1 | Serial management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen at the pin |

## Verification
The bench builds the block with `DIV` = 3, an odd half-period that makes an off-by-one between the low and high phases of `mdc` show up as unequal high time and a wrong frame length, while keeping a frame to 384 clocks so that several reads, writes and an overlapping request fit in a short run. A PHY model in the bench records the line at every rising `mdc` edge and, on reads, changes `mdio_i` only at falling edges, so the sampling point and the choice of the last 16 of 18 bits are both exercised with reply patterns whose first two bits differ from the data.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int SLOT  = 2 * DIV;
  localparam int CW    = (SLOT > 2) ? $clog2(SLOT) : 1;
  localparam int RELEASE_AT = 46;

  logic [CW-1:0] div_cnt;
  logic [5:0]    slot;
  logic [63:0]   sr;
  logic [15:0]   rd_q;
  logic          is_write;

  wire slot_end  = busy && (div_cnt == CW'(SLOT - 1));
  wire sample_pt = busy && !is_write && (slot >= 6'(RELEASE_AT)) && (div_cnt == CW'(DIV - 1));

  assign mdc     = busy && (div_cnt >= CW'(DIV));
  assign mdio_oe = busy && (is_write || (slot < 6'(RELEASE_AT)));
  assign mdio_o  = mdio_oe && sr[63];
  assign rd_data = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      is_write <= 1'b0;
      div_cnt  <= '0;
      slot     <= '0;
      sr       <= '0;
      rd_q     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy     <= 1'b1;
          is_write <= req_write;
          div_cnt  <= '0;
          slot     <= '0;
          sr       <= {32'hFFFF_FFFF,
                       req_write ? {4'b0101, req_phy, req_reg, 2'b10, req_wdata}
                                 : {4'b0110, req_phy, req_reg, 18'd0}};
        end
      end else begin
        div_cnt <= slot_end ? '0 : div_cnt + 1'b1;
        if (slot_end) begin
          sr   <= {sr[62:0], 1'b0};
          slot <= slot + 6'd1;
          if (slot == 6'd63) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        if (sample_pt) rd_q <= {rd_q[14:0], mdio_i};
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_line_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_op_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(is_write));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mdc && !mdio_oe));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  int n_tests = 0, n_fail = 0;
  logic cap_d [0:63];
  logic cap_oe [0:63];
  int ncap = 0;
  int hi_cnt = 0;
  logic [17:0] resp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  initial forever begin
    @(posedge mdc);
    if (ncap < 64) begin
      cap_d[ncap]  = mdio_o;
      cap_oe[ncap] = mdio_oe;
    end
    ncap++;
  end

  initial forever begin
    @(negedge mdc);
    if (ncap >= 46 && ncap < 64) mdio_i = resp[17 - (ncap - 46)];
    else mdio_i = 1'b1;
  end

  initial forever begin
    @(posedge clk);
    if (mdc) hi_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start(input bit w, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d);
    @(negedge clk);
    ncap = 0; hi_cnt = 0;
    req_valid = 1'b1; req_write = w; req_phy = p; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done || n > 5000) break;
    end
  endtask

  task automatic check_frame(input logic [63:0] exp, input int drive_slots,
                             input string req);
    int bad_d = 0, bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      if (cap_oe[i] != (i < drive_slots)) bad_oe++;
      if (i < drive_slots && cap_d[i] != exp[63 - i]) bad_d++;
    end
    chk(ncap == 64, req, "rising mdc edges", ncap, 64);
    chk(bad_d == 0, req, "wrong driven bits", bad_d, 0);
    chk(bad_oe == 0, req, "wrong enable slots", bad_oe, 0);
  endtask

  task automatic t_reset;
    chk(!mdc && !mdio_oe && !busy && !done, "R1", "idle outputs after reset",
        {mdc, mdio_oe, busy, done}, 0);
  endtask

  task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [17:0] rp);
    int n;
    resp = rp;
    start(1'b0, p, r, 16'h0);
    wait_done(n);
    chk(rd_data == rp[15:0], "R5", "read data keeps last 16 samples", rd_data, rp[15:0]);
    check_frame({32'hFFFF_FFFF, 4'b0110, p, r, 18'd0}, 46, "R3 R4");
    chk(cap_d[0] && cap_d[31], "R2", "preamble ones", {cap_d[0], cap_d[31]}, 3);
    chk(n == 128 * DIV, "R8", "read frame length", n, 128 * DIV);
    chk(hi_cnt == 64 * DIV, "R8", "mdc high clocks", hi_cnt, 64 * DIV);
    chk(!busy && !mdc && !mdio_oe, "R10", "released at done", {busy, mdc, mdio_oe}, 0);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
  endtask

  task automatic t_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    int n;
    start(1'b1, p, r, d);
    wait_done(n);
    check_frame({32'hFFFF_FFFF, 4'b0101, p, r, 2'b10, d}, 64, "R2 R6");
    chk(n == 128 * DIV, "R8", "write frame length", n, 128 * DIV);
    chk(!busy && !mdc && !mdio_oe, "R10", "released at done", {busy, mdc, mdio_oe}, 0);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
  endtask

  task automatic t_busy_ignore;
    int n;
    resp = {2'b00, 16'hC3A5};
    start(1'b0, 5'h0A, 5'h03, 16'h0);
    repeat (100) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_phy = 5'h11; req_reg = 5'h1C; req_wdata = 16'hFFFF;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(n);
    check_frame({32'hFFFF_FFFF, 4'b0110, 5'h0A, 5'h03, 18'd0}, 46, "R9");
    chk(rd_data == 16'hC3A5, "R9", "first read result intact", rd_data, 16'hC3A5);
    repeat (200) @(negedge clk);
    chk(!busy && ncap == 64, "R9", "no second transaction", ncap, 64);
    chk(!mdc && !mdio_oe, "R1", "quiet while idle", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_read(5'h01, 5'h01, {2'b10, 16'h1234});
    t_read(5'h1F, 5'h00, {2'b01, 16'hFFFE});
    t_write(5'h00, 5'h1F, 16'hA55A);
    t_write(5'h15, 5'h0A, 16'h0001);
    t_busy_ignore;
    t_read(5'h12, 5'h15, {2'b11, 16'h0000});
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule